// File: doc/BRIEF.md
# Prioritized Load/Shift Register

A parameterizable register, four bits wide by default, that can keep its contents, take a parallel word, or move its contents one place toward either end on each rising clock edge. Three independent enables request a load, a right shift and a left shift. Any combination of them may be raised at once, because a fixed priority resolves them: load first, then right shift, then left shift.

A small encoder turns the three enables into a 2-bit operation code: 00 hold, 01 load, 10 right shift, 11 left shift. Each bit of the register has a 4-to-1 selector in front of its flip-flop, and that code steers the selector. One serial input feeds the most significant bit during a right shift. A second serial input feeds the least significant bit during a left shift. The bit that falls off the far end is dropped. The output is always the current register contents.

Top module: `prio_shift_reg`

## Requirements
- R1: While rst_ni is low, q_o is all zeros, regardless of every other input.
- R2: When load_en_i is 1 at a rising edge, q_o takes data_i at that edge. The shift enables have no effect.
- R3: When load_en_i is 0 and both right_en_i and left_en_i are 1, the register performs a right shift.
- R4: A right shift moves each bit one position toward bit 0, puts msb_in_i into bit WIDTH-1 and discards the old bit 0.
- R5: A left shift (load_en_i and right_en_i both 0, left_en_i 1) moves each bit one position toward bit WIDTH-1, puts lsb_in_i into bit 0 and discards the old top bit.
- R6: With all three enables at 0, q_o keeps its value, whatever data_i and the serial inputs do.
- R7: Starting from 1001 with msb_in_i at 0, four successive right shifts give 0100, 0010, 0001 and 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Parallel load request (highest priority) |
| right_en_i | input | 1 | Right shift request |
| left_en_i | input | 1 | Left shift request (lowest priority) |
| msb_in_i | input | 1 | Serial bit entering the top position on a right shift |
| lsb_in_i | input | 1 | Serial bit entering bit 0 on a left shift |
| data_i | input | WIDTH | Parallel load value |
| q_o | output | WIDTH | Current register contents |

## Verification
Clocked properties in the top module check every cycle that the outcome follows the enable priority. They cover the loaded value, both shift directions with the correct serial bit entering, and hold. The bench scenarios cover the rest: the asynchronous clear, the fixed four-shift walk from 1001 down to zero, and long mixed sequences compared against a reference model. They also show that data_i and the serial inputs have no effect on a held value.

// File: rtl/prio_shift_reg_pkg.sv
package prio_shift_reg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_RIGHT = 2'b10,
    OP_LEFT  = 2'b11
  } op_e;
endpackage

// File: rtl/prio_op_encoder.sv
module prio_op_encoder
  import prio_shift_reg_pkg::*;
(
  input  logic load_en_i,
  input  logic right_en_i,
  input  logic left_en_i,
  output op_e  op_o
);
  // fixed priority: load > right > left
  always_comb begin
    if (load_en_i)       op_o = OP_LOAD;
    else if (right_en_i) op_o = OP_RIGHT;
    else if (left_en_i)  op_o = OP_LEFT;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/prio_bit_cell.sv
module prio_bit_cell
  import prio_shift_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic load_bit_i,
  input  logic from_upper_i,  // neighbour above (right shift source)
  input  logic from_lower_i,  // neighbour below (left shift source)
  output logic q_o
);
  logic d;

  always_comb begin
    unique case (op_i)
      OP_LOAD:  d = load_bit_i;
      OP_RIGHT: d = from_upper_i;
      OP_LEFT:  d = from_lower_i;
      default:  d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import prio_shift_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             right_en_i,
  input  logic             left_en_i,
  input  logic             msb_in_i,
  input  logic             lsb_in_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic [WIDTH-1:0] upper_src;
  logic [WIDTH-1:0] lower_src;

  prio_op_encoder u_enc (
    .load_en_i  (load_en_i),
    .right_en_i (right_en_i),
    .left_en_i  (left_en_i),
    .op_o       (op)
  );

  assign upper_src = {msb_in_i, q_o[MSB:1]};
  assign lower_src = {q_o[MSB-1:0], lsb_in_i};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    prio_bit_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .op_i         (op),
      .load_bit_i   (data_i[i]),
      .from_upper_i (upper_src[i]),
      .from_lower_i (lower_src[i]),
      .q_o          (q_o[i])
    );
  end

  // R2
  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> q_o == $past(data_i));

  // R3, R4
  a_r4_right_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && right_en_i) |=> q_o == {$past(msb_in_i), $past(q_o[MSB:1])});

  // R5
  a_r5_left_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !right_en_i && left_en_i) |=> q_o == {$past(q_o[MSB-1:0]), $past(lsb_in_i)});

  // R6
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !right_en_i && !left_en_i) |=> $stable(q_o));
endmodule

// File: tb/prio_shift_reg_bench.sv
module prio_shift_reg_bench;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_en_i = 1'b0, right_en_i = 1'b0, left_en_i = 1'b0;
  logic         msb_in_i = 1'b0, lsb_in_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] q_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  prio_shift_reg #(.WIDTH(W)) u_prio_shift_reg (
    .clk_i, .rst_ni, .load_en_i, .right_en_i, .left_en_i,
    .msb_in_i, .lsb_in_i, .data_i, .q_o
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, pushes expected result
  task automatic step(input logic l, input logic r, input logic s, input logic [W-1:0] d,
                      input logic mi, input logic li, input string tag);
    item_t it;
    @(negedge clk_i);
    load_en_i = l; right_en_i = r; left_en_i = s;
    data_i = d; msb_in_i = mi; lsb_in_i = li;
    if (l)      model = d;
    else if (r) model = {mi, model[W-1:1]};
    else if (s) model = {model[W-2:0], li};
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares after each edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(q_o, it.exp, it.tag);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: q_o=%b expected=done", q_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds zero even with load requested
    load_en_i = 1'b1; data_i = 4'b1111;
    repeat (2) @(negedge clk_i);
    check(q_o, 4'b0000, "R1 reset");
    load_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(1, 0, 0, 4'b1001, 0, 0, "R2 load");
    // R7: walk 1001 down
    step(0, 1, 0, 4'b1111, 0, 1, "R7 shift1 0100");
    step(0, 1, 0, 4'b1111, 0, 1, "R7 shift2 0010");
    step(0, 1, 0, 4'b1111, 0, 1, "R7 shift3 0001");
    step(0, 1, 0, 4'b1111, 0, 1, "R7 shift4 0000");
    // R2: load beats both shifts
    step(1, 1, 1, 4'b0110, 1, 1, "R2 load over shifts");
    // R3: right beats left
    step(0, 1, 1, 4'b0000, 1, 0, "R3 right over left");
    // R4: msb_in enters top, low bit lost
    step(0, 1, 0, 4'b0000, 0, 1, "R4 right msb_in=0");
    // R5: left shift with lsb_in
    step(0, 0, 1, 4'b1111, 0, 1, "R5 left lsb_in=1");
    step(0, 0, 1, 4'b1111, 1, 0, "R5 left lsb_in=0");
    // R6: hold while data and serial inputs toggle
    step(0, 0, 0, 4'b1010, 1, 1, "R6 hold");
    step(0, 0, 0, 4'b0101, 0, 0, "R6 hold");
    // R2..R6 mixed
    for (int i = 0; i < 60; i++) begin
      logic [8:0] v;
      v = 9'($urandom);
      step(v[0] & v[1], v[2], v[3], v[7:4], v[8], v[1] ^ v[4], "R2-6 mixed");
    end
    @(negedge clk_i);
    @(negedge clk_i);
    // R1: async clear mid-run
    step(1, 0, 0, 4'b1111, 0, 0, "R2 load before clear");
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check(q_o, 4'b0000, "R1 async clear");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule